// File: doc/BRIEF.md
# Rotational Scan Acquisition Sequencer

This block runs one half-turn tomography scan. A stepper-driven turntable carries the object through 600 angular stops, 0.3 degrees apart. At each stop the block waits for the mechanics to settle. It then asks an external converter for one reading from each of eight parallel infrared receivers and hands the eight readings downstream as one sinogram row. The row goes out on a ready/valid stream that feeds a FIFO, and a processor on the far side of that FIFO assembles the sinogram.

Position 0 is the starting angle and is measured without any motion. Before each later position, the block issues a programmable number of step pulses. Pulse width, pulse spacing and settle time are programmable. All configuration is latched when the scan starts. While a row waits for the consumer, the turntable stays where it is, so no angle is skipped. An abort command stops everything at once, drops the row in progress and leaves a sticky flag.

Top module: `scan_seq`

## Requirements
- R1: After reset, `busy`, `aborted`, `out_valid`, `step_out` and `smp_req` are all 0.
- R2: A `cmd_start` pulse while idle begins a scan. On the next cycle `busy` is 1 and `aborted` is 0. Position 0 is sampled with no step pulse before it. A `cmd_start` pulse while busy is ignored, and the scan still delivers every position exactly once.
- R3: Before each position 1 to 599, exactly `cfg_steps` pulses appear on `step_out`, and a value of 0 gives no pulse. Each pulse is high for `cfg_pulse_w` cycles, and 0 counts as 1. Consecutive rising edges are max(`cfg_period`, high time + 1) cycles apart. `dir_out` equals the `cfg_dir` value given at start.
- R4: After the last step pulse of a position ends, at least `cfg_settle` cycles pass before the first sample request of that position.
- R5: At each position, channels are requested in the order 0, 1, …, 7. `smp_req` and `smp_ch` stay unchanged until `smp_ack` is seen. `smp_data` is captured in the cycle `smp_ack` is high.
- R6: Each position yields eight beats in channel order 0 to 7. Every beat carries `out_pos` equal to the position index, and positions ascend from 0. `out_first` is 1 only on the channel 0 beat. `out_data` is the reading captured for `out_ch`.
- R7: `out_last` is 1 only on the channel 7 beat of position 599. The cycle after that beat is accepted, `busy` is 0 and `aborted` is 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, the beat stays on the outputs unchanged. While `out_valid` is 1, there is no step pulse and no sample request.
- R9: `cmd_abort` while busy makes the next cycle show `busy`, `out_valid`, `step_out` and `smp_req` all 0 and `aborted` 1. No further pulses or beats follow. `cmd_abort` while idle has no effect. `aborted` stays set until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Begin a scan (pulse, honoured only when idle) |
| cmd_abort | input | 1 | Stop the running scan (pulse) |
| cfg_dir | input | 1 | Rotation direction, latched at start |
| cfg_steps | input | 8 | Step pulses per angular increment |
| cfg_pulse_w | input | 16 | Step pulse high time in cycles (0 acts as 1) |
| cfg_period | input | 16 | Minimum cycles between step rising edges |
| cfg_settle | input | 16 | Settle wait in cycles before sampling |
| step_out | output | 1 | Stepper step pulse |
| dir_out | output | 1 | Stepper direction |
| smp_req | output | 1 | Reading request, held until acknowledged |
| smp_ch | output | 3 | Receiver channel being requested |
| smp_ack | input | 1 | Reading present on `smp_data` |
| smp_data | input | 16 | Receiver reading |
| out_valid | output | 1 | Stream beat valid |
| out_ready | input | 1 | Consumer accepts beat |
| out_data | output | 16 | Reading |
| out_ch | output | 3 | Channel of this reading |
| out_pos | output | 10 | Angular position index |
| out_first | output | 1 | First beat of a row |
| out_last | output | 1 | Final beat of the scan |
| busy | output | 1 | Scan in progress |
| aborted | output | 1 | Last scan was stopped by abort |

## Verification
The hardest situation to reach is an abort that lands while a row is half delivered and the consumer is stalling. To get there, the bench uses a ready pattern that accepts channels 0 to 2 and then refuses channel 3 indefinitely. It confirms that the stalled beat is frozen, and only then pulses abort. Catching a step pulse mid-flight takes a similar wait on `step_out` before the abort is driven. Three complete 600-position scans cover the rest. They use different step counts, including zero, different pulse timings, and an intermittent stall pattern. In every position the bench counts pulses, checks their width and spacing, and checks the readings against values it supplied itself.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int SCAN_POSITIONS = 600;
    localparam int BEAM_COUNT     = 8;
    localparam int READING_W      = 16;
    localparam int TIMER_W        = 16;
    localparam int STEPS_W        = 8;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_STEP,
        SQ_SETTLE,
        SQ_SAMPLE,
        SQ_EMIT
    } seq_state_e;

    typedef struct packed {
        logic               dir;
        logic [STEPS_W-1:0] steps;
        logic [TIMER_W-1:0] pulse_w;
        logic [TIMER_W-1:0] period;
        logic [TIMER_W-1:0] settle;
    } scan_cfg_t;

    // High time of a step pulse; a zero setting still yields one cycle.
    function automatic logic [TIMER_W-1:0] pulse_high_len(input logic [TIMER_W-1:0] w);
        return (w == '0) ? TIMER_W'(1) : w;
    endfunction

    // Rising-edge spacing: the requested period, but never shorter than high time + 1.
    function automatic logic [TIMER_W:0] pulse_period_len(input logic [TIMER_W-1:0] w,
                                                          input logic [TIMER_W-1:0] p);
        logic [TIMER_W:0] hi_plus;
        hi_plus = {1'b0, pulse_high_len(w)} + (TIMER_W+1)'(1);
        return ({1'b0, p} > hi_plus) ? {1'b0, p} : hi_plus;
    endfunction

endpackage

// File: rtl/scan_stepper.sv
module scan_stepper
    import scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               go,
    input  logic [STEPS_W-1:0] n_steps,
    input  logic [TIMER_W-1:0] pulse_w,
    input  logic [TIMER_W-1:0] period,
    output logic               step,
    output logic               done
);

    localparam logic [TIMER_W:0]   T_ONE = (TIMER_W+1)'(1);
    localparam logic [STEPS_W-1:0] S_ONE = STEPS_W'(1);

    logic               active;
    logic [STEPS_W-1:0] remaining;
    logic [TIMER_W:0]   tcnt;
    logic [TIMER_W-1:0] hi_len;
    logic [TIMER_W:0]   per_len;

    assign hi_len  = pulse_high_len(pulse_w);
    assign per_len = pulse_period_len(pulse_w, period);
    assign step    = active && (tcnt < {1'b0, hi_len});

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            active    <= 1'b0;
            remaining <= '0;
            tcnt      <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active    <= (n_steps != '0);
                remaining <= n_steps;
                tcnt      <= '0;
                done      <= (n_steps == '0);
            end else if (active) begin
                if (tcnt == per_len - T_ONE) begin
                    tcnt      <= '0;
                    remaining <= remaining - S_ONE;
                    if (remaining == S_ONE) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end else begin
                    tcnt <= tcnt + T_ONE;
                end
            end
        end
    end

endmodule

// File: rtl/scan_sampler.sv
module scan_sampler #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 16,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clr,
    input  logic                           go,
    output logic                           req,
    output logic [CH_W-1:0]                ch,
    input  logic                           ack,
    input  logic [DATA_W-1:0]              data,
    output logic                           done,
    output logic [NUM_CH-1:0][DATA_W-1:0]  row
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    logic [NUM_CH-1:0] wr_en;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_wr
        assign wr_en[i] = req && ack && (ch == CH_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            req  <= 1'b0;
            ch   <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                req <= 1'b1;
                ch  <= '0;
            end else if (req && ack) begin
                if (ch == LAST_CH) begin
                    req  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    ch <= ch + CH_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_en[i]) row[i] <= data;
            end
        end
    end

endmodule

// File: rtl/scan_seq.sv
module scan_seq
    import scan_pkg::*;
#(
    parameter int NUM_POS = SCAN_POSITIONS,
    parameter int NUM_CH  = BEAM_COUNT,
    parameter int DATA_W  = READING_W,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int POS_W  = (NUM_POS > 1) ? $clog2(NUM_POS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_start,
    input  logic               cmd_abort,
    input  logic               cfg_dir,
    input  logic [STEPS_W-1:0] cfg_steps,
    input  logic [TIMER_W-1:0] cfg_pulse_w,
    input  logic [TIMER_W-1:0] cfg_period,
    input  logic [TIMER_W-1:0] cfg_settle,
    output logic               step_out,
    output logic               dir_out,
    output logic               smp_req,
    output logic [CH_W-1:0]    smp_ch,
    input  logic               smp_ack,
    input  logic [DATA_W-1:0]  smp_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DATA_W-1:0]  out_data,
    output logic [CH_W-1:0]    out_ch,
    output logic [POS_W-1:0]   out_pos,
    output logic               out_first,
    output logic               out_last,
    output logic               busy,
    output logic               aborted
);

    localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_POS - 1);

    seq_state_e                 state;
    scan_cfg_t                  cfg_q;
    logic [POS_W-1:0]           pos;
    logic [CH_W-1:0]            ech;
    logic [TIMER_W-1:0]         settle_cnt;
    logic                       aborted_q;

    logic                       kill;
    logic                       row_done;
    logic                       step_go;
    logic                       step_done;
    logic                       smp_go;
    logic                       smp_done;
    logic [NUM_CH-1:0][DATA_W-1:0] row;

    assign kill     = cmd_abort && (state != SQ_IDLE);
    assign row_done = (state == SQ_EMIT) && out_ready && (ech == LAST_CH);
    assign step_go  = row_done && (pos != LAST_POS);
    assign smp_go   = (state == SQ_SETTLE) && (settle_cnt == cfg_q.settle);

    scan_stepper u_stepper (
        .clk     (clk),
        .rst     (rst),
        .clr     (kill),
        .go      (step_go),
        .n_steps (cfg_q.steps),
        .pulse_w (cfg_q.pulse_w),
        .period  (cfg_q.period),
        .step    (step_out),
        .done    (step_done)
    );

    scan_sampler #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) u_sampler (
        .clk  (clk),
        .rst  (rst),
        .clr  (kill),
        .go   (smp_go),
        .req  (smp_req),
        .ch   (smp_ch),
        .ack  (smp_ack),
        .data (smp_data),
        .done (smp_done),
        .row  (row)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            cfg_q      <= '0;
            pos        <= '0;
            ech        <= '0;
            settle_cnt <= '0;
            aborted_q  <= 1'b0;
        end else if (kill) begin
            state     <= SQ_IDLE;
            aborted_q <= 1'b1;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (cmd_start) begin
                        cfg_q      <= '{dir: cfg_dir, steps: cfg_steps, pulse_w: cfg_pulse_w,
                                        period: cfg_period, settle: cfg_settle};
                        pos        <= '0;
                        settle_cnt <= '0;
                        aborted_q  <= 1'b0;
                        state      <= SQ_SETTLE;
                    end
                end
                SQ_STEP: begin
                    if (step_done) begin
                        settle_cnt <= '0;
                        state      <= SQ_SETTLE;
                    end
                end
                SQ_SETTLE: begin
                    if (smp_go) state <= SQ_SAMPLE;
                    else        settle_cnt <= settle_cnt + TIMER_W'(1);
                end
                SQ_SAMPLE: begin
                    if (smp_done) begin
                        ech   <= '0;
                        state <= SQ_EMIT;
                    end
                end
                SQ_EMIT: begin
                    if (row_done) begin
                        if (pos == LAST_POS) begin
                            state <= SQ_IDLE;
                        end else begin
                            pos   <= pos + POS_W'(1);
                            state <= SQ_STEP;
                        end
                    end else if (out_ready) begin
                        ech <= ech + CH_W'(1);
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign out_valid = (state == SQ_EMIT);
    assign out_data  = row[ech];
    assign out_ch    = ech;
    assign out_pos   = pos;
    assign out_first = out_valid && (ech == '0);
    assign out_last  = out_valid && (ech == LAST_CH) && (pos == LAST_POS);
    assign busy      = (state != SQ_IDLE);
    assign aborted   = aborted_q;
    assign dir_out   = cfg_q.dir;

endmodule

// File: rtl/scan_seq_checker.sv
module scan_seq_checker #(
    parameter int NUM_POS = 600,
    parameter int NUM_CH  = 8,
    parameter int DATA_W  = 16,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int POS_W  = (NUM_POS > 1) ? $clog2(NUM_POS) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_start,
    input logic              cmd_abort,
    input logic              step_out,
    input logic              smp_req,
    input logic [CH_W-1:0]   smp_ch,
    input logic              smp_ack,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [CH_W-1:0]   out_ch,
    input logic [POS_W-1:0]  out_pos,
    input logic              out_first,
    input logic              out_last,
    input logic              busy,
    input logic              aborted
);

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_start && !cmd_abort) |=> (busy && !aborted));

    p_req_held_r5: assert property (@(posedge clk) disable iff (rst)
        (smp_req && !smp_ack && !cmd_abort) |=> (smp_req && $stable(smp_ch)));

    p_first_is_ch0_r6: assert property (@(posedge clk) disable iff (rst)
        out_first |-> (out_valid && out_ch == '0));

    p_last_beat_r7: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (out_valid && out_ch == CH_W'(NUM_CH - 1) && out_pos == POS_W'(NUM_POS - 1)));

    p_end_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (out_last && out_ready && !cmd_abort) |=> (!busy && !aborted));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !cmd_abort) |=>
            (out_valid && $stable(out_data) && $stable(out_ch) && $stable(out_pos)));

    p_quiet_in_row_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (!step_out && !smp_req));

    p_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_abort) |=> (!busy && aborted && !out_valid && !step_out && !smp_req));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!step_out && !smp_req && !out_valid));

endmodule

bind scan_seq scan_seq_checker #(
    .NUM_POS (NUM_POS),
    .NUM_CH  (NUM_CH),
    .DATA_W  (DATA_W)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .cmd_start (cmd_start),
    .cmd_abort (cmd_abort),
    .step_out  (step_out),
    .smp_req   (smp_req),
    .smp_ch    (smp_ch),
    .smp_ack   (smp_ack),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_ch    (out_ch),
    .out_pos   (out_pos),
    .out_first (out_first),
    .out_last  (out_last),
    .busy      (busy),
    .aborted   (aborted)
);

// File: tb/scan_seq_test.sv
module scan_seq_test;
    import scan_pkg::*;

    localparam int NP = SCAN_POSITIONS;
    localparam int NC = BEAM_COUNT;
    localparam int DW = READING_W;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst = 1'b1;
    logic               cmd_start = 1'b0, cmd_abort = 1'b0;
    logic               cfg_dir = 1'b0;
    logic [STEPS_W-1:0] cfg_steps = '0;
    logic [TIMER_W-1:0] cfg_pulse_w = '0, cfg_period = '0, cfg_settle = '0;
    logic               step_out, dir_out, smp_req, smp_ack = 1'b0;
    logic [2:0]         smp_ch, out_ch;
    logic [DW-1:0]      smp_data = '0, out_data;
    logic               out_valid, out_ready = 1'b0, out_first, out_last, busy, aborted;
    logic [9:0]         out_pos;

    scan_seq uut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_abort(cmd_abort),
        .cfg_dir(cfg_dir), .cfg_steps(cfg_steps), .cfg_pulse_w(cfg_pulse_w),
        .cfg_period(cfg_period), .cfg_settle(cfg_settle),
        .step_out(step_out), .dir_out(dir_out),
        .smp_req(smp_req), .smp_ch(smp_ch), .smp_ack(smp_ack), .smp_data(smp_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_ch(out_ch), .out_pos(out_pos), .out_first(out_first), .out_last(out_last),
        .busy(busy), .aborted(aborted)
    );

    int chk = 0, bad = 0, cyc = 0;

    // reference model state
    int ready_mode = 0;
    int row_idx = 0, exp_ch = 0, smp_exp_ch = 0, burst = 0;
    int step_cnt = 0, step_total = 0, last_rise = 0, last_fall = 0, hi_len = 0;
    int e_steps = 0, e_hi = 1, e_per = 2, e_settle = 0;
    bit e_dir = 0, prev_step = 0, first_req_pend = 0, last_seen = 0;
    bit prev_stall = 0, prev_wait = 0;
    int st_ch = 0, st_pos = 0, wait_ch = 0;
    logic [DW-1:0] st_data = '0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        chk++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [DW-1:0] rdg(input int b, input int c);
        return DW'(b * 131 + c * 17 + 9);
    endfunction

    // monitor and responder: observe outputs, then drive ack/data/ready
    initial begin
        forever begin
            bit ack_now, rdy_now;
            @(negedge clk);
            cyc++;
            if (!rst) begin
                // R3: step pulses
                if (step_out && !prev_step) begin
                    if (step_cnt > 0) check(cyc - last_rise == e_per, "R3 step spacing", cyc - last_rise, e_per);
                    check(dir_out == e_dir, "R3 direction", dir_out, e_dir);
                    step_cnt++; step_total++; last_rise = cyc; hi_len = 0;
                end
                if (step_out) hi_len++;
                if (!step_out && prev_step && busy) begin
                    check(hi_len == e_hi, "R3 pulse width", hi_len, e_hi);
                    last_fall = cyc;
                end
                prev_step = step_out;

                // R8: stalled beat frozen
                if (prev_stall && busy)
                    check(out_valid && out_data == st_data && out_ch == 3'(st_ch) && out_pos == 10'(st_pos),
                          "R8 stalled beat held", out_data, st_data);
                if (out_valid) check(!step_out && !smp_req, "R8 no step/request during row", {step_out, smp_req}, 0);
                if (!busy) check(!out_valid && !smp_req && !step_out, "R9 idle outputs quiet",
                                 {out_valid, smp_req, step_out}, 0);

                // R5: request held until ack
                if (prev_wait && busy) check(smp_req && smp_ch == 3'(wait_ch), "R5 request held", smp_ch, wait_ch);

                // R2/R3/R4: first request of a position
                if (smp_req && first_req_pend) begin
                    first_req_pend = 0;
                    if (row_idx == 0) check(step_cnt == 0, "R2 no step before position 0", step_cnt, 0);
                    else              check(step_cnt == e_steps, "R3 steps per position", step_cnt, e_steps);
                    if (step_cnt > 0) check(cyc - last_fall >= e_settle, "R4 settle time", cyc - last_fall, e_settle);
                end
            end

            ack_now = smp_req && (cyc % 3 != 0);
            if (ack_now) begin
                check(smp_ch == 3'(smp_exp_ch), "R5 channel order", smp_ch, smp_exp_ch);
                smp_data = rdg(burst, int'(smp_ch));
                smp_exp_ch = (smp_exp_ch + 1) % NC;
                if (smp_exp_ch == 0) burst++;
            end
            prev_wait = smp_req && !ack_now;
            wait_ch = int'(smp_ch);
            smp_ack = ack_now;

            case (ready_mode)
                0:       rdy_now = 1'b1;
                1:       rdy_now = (cyc % 5 >= 2);
                default: rdy_now = (out_ch != 3'd3);
            endcase
            if (out_valid && rdy_now && !rst) begin
                check(out_pos == 10'(row_idx), "R6 position index", out_pos, row_idx);
                check(out_ch == 3'(exp_ch), "R6 channel", out_ch, exp_ch);
                check(out_first == (exp_ch == 0), "R6 first marker", out_first, exp_ch == 0);
                check(out_data == rdg(row_idx, exp_ch), "R6 reading", out_data, rdg(row_idx, exp_ch));
                check(out_last == (row_idx == NP - 1 && exp_ch == NC - 1), "R7 end marker", out_last,
                      row_idx == NP - 1 && exp_ch == NC - 1);
                if (out_last) last_seen = 1;
                if (exp_ch == NC - 1) begin
                    exp_ch = 0; row_idx++; first_req_pend = 1; step_cnt = 0;
                end else exp_ch++;
            end
            prev_stall = out_valid && !rdy_now;
            st_data = out_data; st_ch = int'(out_ch); st_pos = int'(out_pos);
            out_ready = rdy_now;
        end
    end

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_scan(input int steps, input int pw, input int per, input int settle, input bit dir);
        while (busy) @(negedge clk);
        @(negedge clk);
        row_idx = 0; exp_ch = 0; smp_exp_ch = 0; burst = 0; step_cnt = 0; step_total = 0;
        first_req_pend = 1; last_seen = 0; prev_wait = 0;
        e_steps = steps; e_hi = (pw == 0) ? 1 : pw;
        e_per = (per > e_hi + 1) ? per : e_hi + 1;
        e_settle = settle; e_dir = dir;
        cfg_steps = STEPS_W'(steps); cfg_pulse_w = TIMER_W'(pw); cfg_period = TIMER_W'(per);
        cfg_settle = TIMER_W'(settle); cfg_dir = dir;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle_cycles(3);
        check(!busy && !aborted && !out_valid && !step_out && !smp_req, "R1 reset state",
              {busy, aborted, out_valid, step_out, smp_req}, 0);
        rst = 1'b0;
        idle_cycles(2);
        check(!busy && !aborted, "R1 idle after reset", {busy, aborted}, 0);
    endtask

    task automatic t_abort_cases();
        int snap;
        ready_mode = 0;
        start_scan(3, 2, 5, 2, 1'b0);
        check(busy && !aborted, "R2 start enters scan", {busy, aborted}, 2);
        while (!step_out) @(negedge clk);
        cmd_abort = 1'b1;
        @(negedge clk);
        cmd_abort = 1'b0;
        check(!busy && aborted && !step_out && !out_valid && !smp_req, "R9 abort during stepping",
              {busy, aborted, step_out, out_valid, smp_req}, 8);
        snap = step_total;
        idle_cycles(20);
        check(step_total == snap && !out_valid, "R9 nothing after abort", step_total, snap);
        cmd_abort = 1'b1;
        @(negedge clk);
        cmd_abort = 1'b0;
        idle_cycles(1);
        check(aborted && !busy, "R9 abort while idle ignored", {aborted, busy}, 2);

        ready_mode = 2;
        start_scan(1, 1, 2, 0, 1'b1);
        check(!aborted && busy, "R2 start clears aborted", aborted, 0);
        while (!(out_valid && out_ch == 3'd3)) @(negedge clk);
        idle_cycles(3);
        check(out_valid && out_ch == 3'd3 && out_pos == 10'd0, "R8 beat held under stall", out_ch, 3);
        cmd_abort = 1'b1;
        @(negedge clk);
        cmd_abort = 1'b0;
        check(!out_valid && aborted && !busy, "R9 abort flushes partial row", {out_valid, aborted, busy}, 2);
        idle_cycles(10);
        check(!out_valid && !step_out, "R9 partial row not resumed", out_valid, 0);
        ready_mode = 0;
    endtask

    task automatic t_full_scan(input int mode, input int steps, input int pw, input int per,
                               input int settle, input bit dir, input bit poke_start);
        ready_mode = mode;
        start_scan(steps, pw, per, settle, dir);
        if (poke_start) begin
            while (row_idx < 100) @(negedge clk);
            cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
        end
        while (busy) @(negedge clk);
        check(row_idx == NP, poke_start ? "R2 restart ignored, all rows delivered" : "R7 all rows delivered",
              row_idx, NP);
        check(last_seen, "R7 end marker seen", last_seen, 1);
        check(!aborted, "R7 normal end not aborted", aborted, 0);
        check(step_total == steps * (NP - 1), "R3 total step pulses", step_total, steps * (NP - 1));
        idle_cycles(5);
        check(!busy && !step_out && !out_valid, "R7 stays idle after scan", busy, 0);
        ready_mode = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", chk, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_abort_cases();
        t_full_scan(1, 1, 2, 4, 3, 1'b1, 1'b0);
        t_full_scan(0, 2, 0, 0, 0, 1'b0, 1'b1);
        t_full_scan(1, 0, 3, 3, 1, 1'b1, 1'b0);
        $display("  == %0d vectors applied, %0d miscompares ==", chk, bad);
        $finish;
    end

endmodule